// File: doc/BRIEF.md
# PS/2 Mouse Resend and Error Responder

This block sits on the device side of a PS/2 mouse, between the serial link engine and the command logic. Every byte the host sends arrives here first as a one-cycle strobe with its data and a parity-error flag. The block classifies the byte, answers malformed or unknown input with a request to repeat, and escalates to an error code when two bad inputs arrive in a row. Every valid command except the host's own repeat request produces a one-cycle pulse that clears the movement accumulators.

The link engine reports each outgoing packet (one reply byte, or a three-byte movement report in streaming operation) once it has gone out with no abort. The block keeps a copy. When the host asks for a repeat, the block plays the whole packet back through a ready/valid byte stream, first byte first. The byte that follows a command that takes an operand (set resolution 0xE8, set sample rate 0xF3) is an operand, not a command. It gets no validity check and has no effect on the accumulators.

Top module: `ps2_resend_responder`

## Requirements
- R1: After reset, tx_valid and acc_clear are low and the stored packet length is zero.
- R2: A received byte with rx_parity_err set, or one outside the known command set, is answered with a single 0xFE on the transmit stream, with tx_valid rising in the cycle after rx_valid. The known set is 0xE6 to 0xEC, 0xEE, 0xF0, 0xF2 to 0xF6, 0xFE and 0xFF.
- R3: An invalid byte that directly follows another invalid byte is answered with 0xFC instead of 0xFE. This restarts the count, so a third invalid byte in a row is answered with 0xFE again.
- R4: Any byte accepted as valid resets the count of consecutive invalid bytes. This includes a command, an operand, or the repeat request 0xFE.
- R5: A valid command other than 0xFE drives acc_clear high for exactly the one cycle after its rx_valid, and queues no transmit byte.
- R6: A received 0xFE (not as an operand) replays the stored packet in order, starting with pkt_data[7:0]. It does not pulse acc_clear.
- R7: The stored packet changes only on a pkt_commit whose pkt_len is 1 to 3. A commit with length zero leaves the previous packet in place.
- R8: The byte after 0xE8 or 0xF3 is taken as an operand of any value: it gets no response and no acc_clear. If that byte has a parity error, it is answered as in R2, and the operand is still expected next.
- R9: While tx_valid is high and tx_ready is low, tx_valid and tx_data hold. The stream moves on only on a cycle with both high.
- R10: A newly received byte abandons any response bytes not yet accepted, and starts its own response (if any) in their place.
- R11: A repeat request while no packet is stored produces no transmit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a host byte was received |
| rx_data | input | 8 | Received byte |
| rx_parity_err | input | 1 | The received byte failed the odd-parity check |
| pkt_commit | input | 1 | A device packet finished transmitting without abort |
| pkt_len | input | 2 | Byte count of the committed packet (1 to 3) |
| pkt_data | input | 24 | Committed packet; first byte in bits 7:0 |
| tx_valid | output | 1 | A response byte is offered to the link engine |
| tx_ready | input | 1 | The link engine accepts the offered byte |
| tx_data | output | 8 | Response byte |
| acc_clear | output | 1 | One-cycle pulse: clear the movement accumulators |

## Verification
A wrong strike count shows up at the very next bad byte, as 0xFC where 0xFE was due or the reverse. Because the count restarts after every error code, a count that is off by one stays wrong for every later pair of bad bytes. A lost operand-pending flag makes the next operand either draw a spurious 0xFE or raise acc_clear, one cycle after the operand arrives. A stale or misindexed packet buffer only appears when the host next asks for a repeat. The scoreboard therefore follows every commit, including the ignored zero-length one, with a replay and compares each replayed byte in order.

// File: rtl/ps2r_pkg.sv
`timescale 1ns/1ps
// Shared constants, byte classification type and command-set helpers for the
// resend/error responder. Assumes an 8-bit host byte.
package ps2r_pkg;

    localparam logic [7:0] HOST_RESEND  = 8'hFE;
    localparam logic [7:0] RSP_AGAIN    = 8'hFE;
    localparam logic [7:0] RSP_ERROR    = 8'hFC;
    localparam logic [7:0] CMD_SET_RES  = 8'hE8;
    localparam logic [7:0] CMD_SET_RATE = 8'hF3;

    typedef enum logic [2:0] {
        RX_NONE,
        RX_OPERAND,
        RX_CMD,
        RX_RESEND,
        RX_BAD_FIRST,
        RX_BAD_LAST
    } rx_kind_e;

    // True when the byte is a command the mouse recognises.
    function automatic logic cmd_known(input logic [7:0] b);
        logic hit;
        hit = 1'b0;
        if (b >= 8'hE6 && b <= 8'hEC) hit = 1'b1;
        if (b == 8'hEE || b == 8'hF0) hit = 1'b1;
        if (b >= 8'hF2 && b <= 8'hF6) hit = 1'b1;
        if (b == 8'hFE || b == 8'hFF) hit = 1'b1;
        return hit;
    endfunction

    // True when the command is followed by a one-byte operand.
    function automatic logic cmd_has_operand(input logic [7:0] b);
        return (b == CMD_SET_RES) || (b == CMD_SET_RATE);
    endfunction

endpackage

// File: rtl/ps2r_classifier.sv
`timescale 1ns/1ps
// Classifies each received host byte (operand, command, repeat request, or
// invalid with strike level) and raises the accumulator-clear pulse.
// Assumes rx_valid is a single-cycle strobe per byte.
module ps2r_classifier
    import ps2r_pkg::*;
#(
    parameter int STRIKE_LIMIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_parity_err,
    output rx_kind_e   rx_kind,
    output logic       acc_clear
);
    localparam int SW = (STRIKE_LIMIT > 2) ? $clog2(STRIKE_LIMIT) : 1;
    localparam logic [SW-1:0] STRIKE_TOP = SW'(STRIKE_LIMIT - 1);

    logic          operand_due;
    logic [SW-1:0] strikes;
    logic          bad;

    // Purpose: decide what the current byte is, from its content and history.
    always_comb begin
        bad = 1'b0;
        rx_kind = RX_NONE;
        if (rx_valid) begin
            if (rx_parity_err)              bad = 1'b1;
            else if (operand_due)           rx_kind = RX_OPERAND;
            else if (rx_data == HOST_RESEND) rx_kind = RX_RESEND;
            else if (cmd_known(rx_data))    rx_kind = RX_CMD;
            else                            bad = 1'b1;
            if (bad) rx_kind = (strikes == STRIKE_TOP) ? RX_BAD_LAST : RX_BAD_FIRST;
        end
    end

    // Purpose: track operand expectation, strike count and the clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            operand_due <= 1'b0;
            strikes     <= '0;
            acc_clear   <= 1'b0;
        end else begin
            acc_clear <= (rx_kind == RX_CMD);
            unique case (rx_kind)
                RX_BAD_FIRST: strikes <= strikes + SW'(1);
                RX_BAD_LAST:  strikes <= '0;
                RX_OPERAND: begin
                    strikes     <= '0;
                    operand_due <= 1'b0;
                end
                RX_CMD: begin
                    strikes     <= '0;
                    operand_due <= cmd_has_operand(rx_data);
                end
                RX_RESEND: strikes <= '0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ps2r_pkt_store.sv
`timescale 1ns/1ps
// Holds the last packet that left the device in full, with its length.
// Assumes pkt_commit is only raised after an unaborted transmission.
module ps2r_pkt_store #(
    parameter int PKT_MAX = 3,
    localparam int LEN_W  = $clog2(PKT_MAX + 1),
    localparam int IDX_W  = (PKT_MAX > 1) ? $clog2(PKT_MAX) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pkt_commit,
    input  logic [LEN_W-1:0]     pkt_len,
    input  logic [PKT_MAX*8-1:0] pkt_data,
    input  logic [LEN_W-1:0]     rd_idx,
    output logic [7:0]           rd_byte,
    output logic [LEN_W-1:0]     stored_len
);
    logic [7:0] bytes [PKT_MAX];
    logic       take;

    assign take = pkt_commit && (pkt_len != '0) &&
                  ({1'b0, pkt_len} <= (LEN_W + 1)'(PKT_MAX));

    // Purpose: capture the packet length on an accepted commit.
    always_ff @(posedge clk) begin
        if (!rst_n)    stored_len <= '0;
        else if (take) stored_len <= pkt_len;
    end

    for (genvar g = 0; g < PKT_MAX; g++) begin : g_byte
        // Purpose: capture one packet byte on an accepted commit.
        always_ff @(posedge clk) begin
            if (!rst_n)    bytes[g] <= '0;
            else if (take) bytes[g] <= pkt_data[g*8 +: 8];
        end
    end

    // Purpose: read port for the replay sequencer.
    always_comb begin
        rd_byte = '0;
        if (rd_idx < LEN_W'(PKT_MAX)) rd_byte = bytes[rd_idx[IDX_W-1:0]];
    end

endmodule

// File: rtl/ps2r_tx_seq.sv
`timescale 1ns/1ps
// Emits the response to each classified byte as a ready/valid byte stream:
// one error byte, or a replay of the stored packet. A new classified byte
// replaces anything still unsent. Assumes no commit lands during a replay.
module ps2r_tx_seq
    import ps2r_pkg::*;
#(
    parameter int PKT_MAX = 3,
    localparam int LEN_W  = $clog2(PKT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rx_kind_e         rx_kind,
    input  logic [LEN_W-1:0] stored_len,
    input  logic [7:0]       rd_byte,
    output logic [LEN_W-1:0] rd_idx,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_data
);
    logic             busy;
    logic             replay;
    logic [7:0]       err_byte;
    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] last;

    // Purpose: load a new response or step through the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            replay   <= 1'b0;
            err_byte <= '0;
            idx      <= '0;
            last     <= '0;
        end else if (rx_kind != RX_NONE) begin
            idx <= '0;
            unique case (rx_kind)
                RX_BAD_FIRST: begin
                    busy     <= 1'b1;
                    replay   <= 1'b0;
                    err_byte <= RSP_AGAIN;
                end
                RX_BAD_LAST: begin
                    busy     <= 1'b1;
                    replay   <= 1'b0;
                    err_byte <= RSP_ERROR;
                end
                RX_RESEND: begin
                    busy   <= (stored_len != '0);
                    replay <= 1'b1;
                    last   <= stored_len - LEN_W'(1);
                end
                default: busy <= 1'b0;
            endcase
        end else if (busy && tx_ready) begin
            if (!replay || idx == last) busy <= 1'b0;
            else                        idx  <= idx + LEN_W'(1);
        end
    end

    // Purpose: present the current response byte.
    always_comb begin
        tx_valid = busy;
        tx_data  = replay ? rd_byte : err_byte;
        rd_idx   = idx;
    end

endmodule

// File: rtl/ps2_resend_responder.sv
`timescale 1ns/1ps
// Top of the resend/error responder: classifier, packet store and transmit
// sequencer. Assumes host bytes arrive as single-cycle strobes from the link
// engine and that the host waits for a response before sending again.
module ps2_resend_responder
    import ps2r_pkg::*;
#(
    parameter int PKT_MAX      = 3,
    parameter int STRIKE_LIMIT = 2,
    localparam int LEN_W       = $clog2(PKT_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_data,
    input  logic                 rx_parity_err,
    input  logic                 pkt_commit,
    input  logic [LEN_W-1:0]     pkt_len,
    input  logic [PKT_MAX*8-1:0] pkt_data,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [7:0]           tx_data,
    output logic                 acc_clear
);
    rx_kind_e         rx_kind;
    logic [LEN_W-1:0] stored_len;
    logic [LEN_W-1:0] rd_idx;
    logic [7:0]       rd_byte;

    ps2r_classifier #(.STRIKE_LIMIT(STRIKE_LIMIT)) u_class (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_parity_err (rx_parity_err),
        .rx_kind       (rx_kind),
        .acc_clear     (acc_clear)
    );

    ps2r_pkt_store #(.PKT_MAX(PKT_MAX)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_commit (pkt_commit),
        .pkt_len    (pkt_len),
        .pkt_data   (pkt_data),
        .rd_idx     (rd_idx),
        .rd_byte    (rd_byte),
        .stored_len (stored_len)
    );

    ps2r_tx_seq #(.PKT_MAX(PKT_MAX)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_kind    (rx_kind),
        .stored_len (stored_len),
        .rd_byte    (rd_byte),
        .rd_idx     (rd_idx),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_data    (tx_data)
    );

endmodule

// File: rtl/ps2r_checker.sv
`timescale 1ns/1ps
// Port-level temporal checks for the resend/error responder, bound to the top.
module ps2r_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_parity_err,
    input logic       pkt_commit,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       acc_clear
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!tx_valid && !acc_clear));

    assert_parity_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_parity_err) |=> (tx_valid && (tx_data == 8'hFE || tx_data == 8'hFC)));

    assert_clear_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clear |-> ($past(rx_valid) && !$past(rx_parity_err)));

    assert_resend_no_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_parity_err && rx_data == 8'hFE) |=> !acc_clear);

    assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !rx_valid && !pkt_commit) |=> (tx_valid && $stable(tx_data)));

    assert_clear_cancels_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clear |-> !tx_valid);

endmodule

bind ps2_resend_responder ps2r_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_parity_err (rx_parity_err),
    .pkt_commit    (pkt_commit),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data),
    .acc_clear     (acc_clear)
);

// File: tb/ps2_resend_responder_tb_top.sv
`timescale 1ns/1ps
module ps2_resend_responder_tb_top;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_parity_err = 1'b0;
    logic        pkt_commit = 1'b0;
    logic [1:0]  pkt_len = '0;
    logic [23:0] pkt_data = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        acc_clear;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    // Bench model state, kept from the requirements alone.
    int         m_strike = 0;
    bit         m_operand = 1'b0;
    logic [7:0] m_pkt [3] = '{8'h00, 8'h00, 8'h00};
    int         m_len = 0;

    always #10 clk = ~clk;

    ps2_resend_responder dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_parity_err(rx_parity_err), .pkt_commit(pkt_commit), .pkt_len(pkt_len),
        .pkt_data(pkt_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .acc_clear(acc_clear)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic bit known_cmd(input logic [7:0] b);
        case (b)
            8'hE6, 8'hE7, 8'hE8, 8'hE9, 8'hEA, 8'hEB, 8'hEC, 8'hEE, 8'hF0,
            8'hF2, 8'hF3, 8'hF4, 8'hF5, 8'hF6, 8'hFE, 8'hFF: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Monitor: pops and compares every accepted response byte.
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10/R11 unexpected byte", tx_data, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(tx_data == e.val, e.req, tx_data, e.val);
            end
        end
    end

    task automatic push(input logic [7:0] v, input string req);
        exp_t e;
        e.val = v;
        e.req = req;
        exp_q.push_back(e);
    endtask

    // Driver: updates the model, queues expectations, drives one byte and
    // checks the accumulator-clear pulse in the following cycle.
    task automatic send_byte(input logic [7:0] d, input bit perr, input string req);
        bit exp_clr;
        exp_clr = 1'b0;
        exp_q.delete();
        if (perr || (!m_operand && !known_cmd(d))) begin
            if (m_strike == 1) begin
                push(8'hFC, req);
                m_strike = 0;
            end else begin
                push(8'hFE, req);
                m_strike = 1;
            end
        end else if (m_operand) begin
            m_operand = 1'b0;
            m_strike = 0;
        end else if (d == 8'hFE) begin
            m_strike = 0;
            for (int i = 0; i < m_len; i++) push(m_pkt[i], req);
        end else begin
            m_strike = 0;
            exp_clr = 1'b1;
            m_operand = (d == 8'hE8 || d == 8'hF3);
        end
        @(posedge clk); #2;
        rx_valid = 1'b1;
        rx_data = d;
        rx_parity_err = perr;
        @(posedge clk); #2;
        rx_valid = 1'b0;
        rx_parity_err = 1'b0;
        @(negedge clk);
        check(acc_clear == exp_clr, {req, " acc_clear"}, acc_clear, exp_clr);
    endtask

    task automatic commit(input logic [1:0] len, input logic [23:0] data);
        @(posedge clk); #2;
        pkt_commit = 1'b1;
        pkt_len = len;
        pkt_data = data;
        @(posedge clk); #2;
        pkt_commit = 1'b0;
        if (len != 0) begin
            m_len = len;
            for (int i = 0; i < 3; i++) m_pkt[i] = data[i*8 +: 8];
        end
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 20; i++) begin
            if (exp_q.size() == 0 && !tx_valid) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0 && !tx_valid, {req, " drained"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(!tx_valid, "R1 tx_valid after reset", tx_valid, 0);
        check(!acc_clear, "R1 acc_clear after reset", acc_clear, 0);

        // R11: repeat request with an empty store sends nothing.
        send_byte(8'hFE, 1'b0, "R11");
        drain("R11");

        // R6: single-byte packet replay.
        commit(2'd1, 24'h0000FA);
        send_byte(8'hFE, 1'b0, "R6 one byte");
        drain("R6");

        // R6: three-byte stream packet replay in order.
        commit(2'd3, 24'h341208);
        send_byte(8'hFE, 1'b0, "R6 three bytes");
        drain("R6");

        // R7: zero-length commit leaves the stored packet.
        commit(2'd0, 24'hAABBCC);
        send_byte(8'hFE, 1'b0, "R7 zero length ignored");
        drain("R7");

        // R5: valid commands pulse acc_clear, no transmit byte.
        send_byte(8'hF4, 1'b0, "R5 F4");
        drain("R5");
        send_byte(8'hE6, 1'b0, "R5 E6");
        send_byte(8'hFF, 1'b0, "R5 FF");
        drain("R5");

        // R2 and R3: FE, then FC, then FE again.
        send_byte(8'h55, 1'b0, "R2 unknown byte");
        drain("R2");
        send_byte(8'hFD, 1'b0, "R3 second invalid");
        drain("R3");
        send_byte(8'h10, 1'b0, "R3 count restarts");
        drain("R3");

        // R4: a valid command between bad bytes resets the count.
        send_byte(8'hF5, 1'b0, "R4 valid command");
        send_byte(8'hF4, 1'b1, "R2 parity error");
        drain("R2");
        send_byte(8'hF6, 1'b0, "R4 reset count");
        send_byte(8'hED, 1'b0, "R4 first after reset");
        drain("R4");
        send_byte(8'hFE, 1'b0, "R4 resend resets count");
        drain("R4");
        send_byte(8'hEF, 1'b0, "R4 first after resend");
        drain("R4");

        // R8: operand handling.
        send_byte(8'hF3, 1'b0, "R8 rate command");
        send_byte(8'h55, 1'b0, "R8 operand accepted");
        drain("R8");
        send_byte(8'hE8, 1'b0, "R8 resolution command");
        send_byte(8'h03, 1'b1, "R8 operand parity error");
        drain("R8");
        send_byte(8'h03, 1'b0, "R8 operand still due");
        drain("R8");
        send_byte(8'h55, 1'b0, "R4 after operand");
        drain("R4");

        // R9: stall holds the first replay byte.
        tx_ready = 1'b0;
        send_byte(8'hFE, 1'b0, "R9 replay under stall");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(tx_valid && tx_data == 8'h08, "R9 hold", tx_data, 8'h08);
        end
        tx_ready = 1'b1;
        drain("R9");

        // R10: a new byte abandons an unsent response.
        tx_ready = 1'b0;
        send_byte(8'h20, 1'b0, "R10 pending error");
        @(negedge clk);
        check(tx_valid && tx_data == 8'hFE, "R10 pending", tx_data, 8'hFE);
        send_byte(8'hF4, 1'b0, "R10 cancel");
        @(negedge clk);
        check(!tx_valid, "R10 abandoned", tx_valid, 0);
        tx_ready = 1'b1;
        drain("R10");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule